// File: doc/BRIEF.md
# Two-Clock Registered-Input Dual-Port Memory

This block is a true dual-port memory of 4096 nine-bit words. It has a left port and a right port, and each port runs on its own clock. A port samples its address, write data, select, direction and hold inputs on the rising edge of its clock. A write lands in the array at that edge. A read captures the addressed word at that edge and presents it after the edge. All nine bits are ordinary data, so a user who wants parity can keep it in the top bit.

Each port has four controls:
- an active-high hold input, which freezes the port for a cycle so that nothing is captured and nothing changes;
- an active-low select input, which deselects the port and stops it driving;
- a direction input, high for read and low for write;
- an active-low output enable, which gates the read data combinationally.

Tri-state pins are modelled by a drive flag together with read data forced to zero whenever the port is not driving. Both ports may reach the array in the same cycle, including at the same address. In that case a read returns the word as it stood before the edge. When both ports write one word on a common edge, the left port's data is the one kept.

Top module: `dpram_sync_2clk`

## Requirements
- R1: The array holds 2^ADDR_W words (4096 by default) of DATA_W bits (9 by default). A read returns the last word written to that address by either port, with all nine bits intact, the top bit included.
- R2: A port reads when, at a rising edge of its clock, hold=0, sel_n=0 and rd_wr=1. From that edge on, rvalid is 1, and with oe_n=0, drive is 1 and rdata carries the addressed word.
- R3: When hold=1 at a rising edge, the port ignores sel_n, rd_wr, addr and wdata at that edge. No write takes place, and rvalid and the held read word stay as they were.
- R4: A port writes wdata to addr when, at a rising edge, hold=0, sel_n=0 and rd_wr=0. After that edge, rvalid=0, drive=0 and rdata=0.
- R5: When hold=0 and sel_n=1 at a rising edge, the port is deselected from that edge on: rvalid=0, drive=0 and rdata=0, even with oe_n=0.
- R6: drive equals rvalid AND NOT oe_n, and it follows oe_n with no clock edge. rdata is zero whenever drive=0.
- R7: Suppose one port writes an address and the other port reads the same address on the same edge. The reader gets the old word. A read of that address on any later edge returns the new word.
- R8: If both ports write the same address on the same edge, the left port's data is stored. This holds every time it happens.
- R9: While rst_n=0 (asynchronous, active low), the port's registered controls are in the deselected state, with rvalid=0, drive=0 and rdata=0. Reset does not clear the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst_n | input | 1 | Left port asynchronous reset, active low |
| l_hold | input | 1 | Left port freeze, active high |
| l_sel_n | input | 1 | Left port select, active low |
| l_rd_wr | input | 1 | Left direction: 1 read, 0 write |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_oe_n | input | 1 | Left asynchronous output enable, active low |
| l_rdata | output | DATA_W | Left read data, zero when not driving |
| l_rvalid | output | 1 | Left registered read-active flag |
| l_drive | output | 1 | Left output driving flag |
| r_clk | input | 1 | Right port clock |
| r_rst_n | input | 1 | Right port asynchronous reset, active low |
| r_hold | input | 1 | Right port freeze, active high |
| r_sel_n | input | 1 | Right port select, active low |
| r_rd_wr | input | 1 | Right direction: 1 read, 0 write |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_oe_n | input | 1 | Right asynchronous output enable, active low |
| r_rdata | output | DATA_W | Right read data, zero when not driving |
| r_rvalid | output | 1 | Right registered read-active flag |
| r_drive | output | 1 | Right output driving flag |

## Verification
Two functions can land on the same edge: a write on one port and an access to the same word on the other port, which is either a read or a second write. The bench runs both ports from a shared clock. It provokes these cases directly, writing and reading one word across ports, and writing one word from both sides. It also produces them in a random run that, a quarter of the time, forces the right port onto the left port's address. A reference array judges each case: reads are answered from the array as it stood before the edge, and on a double write only the left port's write is applied.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  localparam int unsigned PORTS = 2;

  typedef struct packed {
    logic desel;
    logic rd;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{desel: 1'b1, rd: 1'b1};

  function automatic logic ctl_reads(input ctl_t c);
    return !c.desel && c.rd;
  endfunction

  function automatic logic ctl_writes(input ctl_t c);
    return !c.desel && !c.rd;
  endfunction

  function automatic logic out_enabled(input logic active, input logic oe_n);
    return active && !oe_n;
  endfunction

endpackage

// File: rtl/dpram_xor_bank.sv
module dpram_xor_bank #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 9,
  parameter int unsigned RD_PORTS = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wval,
  input  logic [ADDR_W-1:0] raddr [RD_PORTS],
  output logic [DATA_W-1:0] rval  [RD_PORTS]
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wval;
  end

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
    assign rval[g] = cells[raddr[g]];
  end
endmodule

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              sel_n,
  input  logic              rd_wr,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] word_now,
  output logic              wr_fire,
  output logic              rvalid,
  output logic              drive,
  output logic [DATA_W-1:0] rdata
);
  ctl_t              ctl_d;
  ctl_t              ctl_q;
  logic              rd_fire;
  logic [DATA_W-1:0] word_q;

  assign ctl_d   = '{desel: sel_n, rd: rd_wr};
  assign wr_fire = !hold && ctl_writes(ctl_d);
  assign rd_fire = !hold && ctl_reads(ctl_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_IDLE;
      word_q <= '0;
    end else if (!hold) begin
      ctl_q <= ctl_d;
      if (rd_fire) word_q <= word_now;
    end
  end

  assign rvalid = ctl_reads(ctl_q);
  assign drive  = out_enabled(rvalid, oe_n);
  assign rdata  = drive ? word_q : '0;
endmodule

// File: rtl/dpram_sync_2clk.sv
module dpram_sync_2clk
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 9
) (
  input  logic              l_clk,
  input  logic              l_rst_n,
  input  logic              l_hold,
  input  logic              l_sel_n,
  input  logic              l_rd_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_oe_n,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_drive,
  input  logic              r_clk,
  input  logic              r_rst_n,
  input  logic              r_hold,
  input  logic              r_sel_n,
  input  logic              r_rd_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_oe_n,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_drive
);
  function automatic logic [DATA_W-1:0] fold_word(input logic [DATA_W-1:0] x,
                                                  input logic [DATA_W-1:0] y);
    return x ^ y;
  endfunction

  logic              p_clk     [PORTS];
  logic              p_rst_n   [PORTS];
  logic              p_hold    [PORTS];
  logic              p_sel_n   [PORTS];
  logic              p_rd_wr   [PORTS];
  logic              p_oe_n    [PORTS];
  logic [ADDR_W-1:0] p_addr    [PORTS];
  logic [DATA_W-1:0] p_wdata   [PORTS];
  logic [DATA_W-1:0] p_word    [PORTS];
  logic              p_wr_fire [PORTS];
  logic              p_rvalid  [PORTS];
  logic              p_drive   [PORTS];
  logic [DATA_W-1:0] p_rdata   [PORTS];
  logic              bank_we   [PORTS];
  logic [DATA_W-1:0] bank_wval [PORTS];
  logic [DATA_W-1:0] bank_rd   [PORTS][PORTS];

  logic same_word_clash;
  logic l_wr_event;
  logic r_wr_event;

  assign p_clk[0]   = l_clk;   assign p_clk[1]   = r_clk;
  assign p_rst_n[0] = l_rst_n; assign p_rst_n[1] = r_rst_n;
  assign p_hold[0]  = l_hold;  assign p_hold[1]  = r_hold;
  assign p_sel_n[0] = l_sel_n; assign p_sel_n[1] = r_sel_n;
  assign p_rd_wr[0] = l_rd_wr; assign p_rd_wr[1] = r_rd_wr;
  assign p_oe_n[0]  = l_oe_n;  assign p_oe_n[1]  = r_oe_n;
  assign p_addr[0]  = l_addr;  assign p_addr[1]  = r_addr;
  assign p_wdata[0] = l_wdata; assign p_wdata[1] = r_wdata;

  assign same_word_clash = p_wr_fire[0] && p_wr_fire[1] && (p_addr[0] == p_addr[1]);
  assign l_wr_event      = p_wr_fire[0];
  assign r_wr_event      = p_wr_fire[1];

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam int unsigned OTHER = PORTS - 1 - p;
    localparam bit          YIELDS = (p != 0);

    assign p_word[p]    = fold_word(bank_rd[0][p], bank_rd[1][p]);
    assign bank_wval[p] = fold_word(p_wdata[p], bank_rd[OTHER][p]);
    assign bank_we[p]   = p_wr_fire[p] && !(YIELDS && same_word_clash);

    dpram_port_ctl #(.DATA_W(DATA_W)) ctl_i (
      .clk      (p_clk[p]),
      .rst_n    (p_rst_n[p]),
      .hold     (p_hold[p]),
      .sel_n    (p_sel_n[p]),
      .rd_wr    (p_rd_wr[p]),
      .oe_n     (p_oe_n[p]),
      .word_now (p_word[p]),
      .wr_fire  (p_wr_fire[p]),
      .rvalid   (p_rvalid[p]),
      .drive    (p_drive[p]),
      .rdata    (p_rdata[p])
    );

    dpram_xor_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_PORTS(PORTS)) bank_i (
      .clk   (p_clk[p]),
      .we    (bank_we[p]),
      .waddr (p_addr[p]),
      .wval  (bank_wval[p]),
      .raddr (p_addr),
      .rval  (bank_rd[p])
    );
  end

  assign l_rdata  = p_rdata[0];
  assign l_rvalid = p_rvalid[0];
  assign l_drive  = p_drive[0];
  assign r_rdata  = p_rdata[1];
  assign r_rvalid = p_rvalid[1];
  assign r_drive  = p_drive[1];
endmodule

// File: rtl/dpram_sync_2clk_chk.sv
module dpram_sync_2clk_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 9
) (
  input logic              l_clk,
  input logic              l_rst_n,
  input logic              l_hold,
  input logic              l_sel_n,
  input logic              l_rd_wr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_rvalid,
  input logic              l_drive,
  input logic              l_wr_event,
  input logic              r_clk,
  input logic              r_rst_n,
  input logic              r_hold,
  input logic              r_sel_n,
  input logic              r_rd_wr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_rvalid,
  input logic              r_drive,
  input logic              r_wr_event
);
  localparam int unsigned AW_SEEN = ADDR_W;

  // R2
  l_read_valid_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (!l_hold && !l_sel_n && l_rd_wr) |=> l_rvalid);
  // R2
  r_read_valid_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    (!r_hold && !r_sel_n && r_rd_wr) |=> r_rvalid);
  // R3
  l_hold_freeze_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    l_hold |=> $stable(l_rvalid));
  // R3
  r_hold_freeze_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    r_hold |=> $stable(r_rvalid));
  // R4
  l_write_quiet_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    l_wr_event |=> (!l_rvalid && !l_drive));
  // R4
  r_write_quiet_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    r_wr_event |=> (!r_rvalid && !r_drive));
  // R5
  l_desel_float_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (!l_hold && l_sel_n) |=> (!l_drive && l_rdata == '0));
  // R5
  r_desel_float_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    (!r_hold && r_sel_n) |=> (!r_drive && r_rdata == '0));
  // R9
  l_reset_idle_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    $rose(l_rst_n) |-> (!l_rvalid && AW_SEEN > 0));
  // R9
  r_reset_idle_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    $rose(r_rst_n) |-> !r_rvalid);
endmodule

bind dpram_sync_2clk dpram_sync_2clk_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/dpram_sync_2clk_tb.sv
module dpram_sync_2clk_tb_top;
  localparam int AW = 12;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int OP_IDLE = 0;
  localparam int OP_RD   = 1;
  localparam int OP_WR   = 2;
  localparam int OP_HOLD = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [1:0]    hold, sel_n, rd_wr, oe_n;
  logic [AW-1:0] addr  [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic          rvalid[2];
  logic          drive [2];

  logic [DW-1:0] ref_mem [DEPTH];
  logic          exp_valid [2];
  logic [DW-1:0] exp_word  [2];
  int n_chk = 0;
  int n_err = 0;
  bit reported = 1'b0;

  dpram_sync_2clk #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .l_clk(clk), .l_rst_n(rst_n), .l_hold(hold[0]), .l_sel_n(sel_n[0]), .l_rd_wr(rd_wr[0]),
    .l_addr(addr[0]), .l_wdata(wdata[0]), .l_oe_n(oe_n[0]),
    .l_rdata(rdata[0]), .l_rvalid(rvalid[0]), .l_drive(drive[0]),
    .r_clk(clk), .r_rst_n(rst_n), .r_hold(hold[1]), .r_sel_n(sel_n[1]), .r_rd_wr(rd_wr[1]),
    .r_addr(addr[1]), .r_wdata(wdata[1]), .r_oe_n(oe_n[1]),
    .r_rdata(rdata[1]), .r_rvalid(rvalid[1]), .r_drive(drive[1])
  );

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
  endtask

  task automatic check(string tag, int p, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s port%0d %s: actual=%0h expected=%0h", tag, p, what, act, exp);
    end
  endtask

  task automatic check_ports(string tag);
    for (int p = 0; p < 2; p++) begin
      check(tag, p, "rvalid", 32'(rvalid[p]), 32'(exp_valid[p]));
      check(tag, p, "drive",  32'(drive[p]),  32'(exp_valid[p]));
      check(tag, p, "rdata",  32'(rdata[p]),  exp_valid[p] ? 32'(exp_word[p]) : 32'd0);
    end
  endtask

  // One edge on both ports; expectations from the reference array before the edge.
  task automatic step(int op0, int ad0, int dt0, int op1, int ad1, int dt1, string tag);
    int op[2];
    int ad[2];
    int dt[2];
    op[0] = op0; op[1] = op1; ad[0] = ad0; ad[1] = ad1; dt[0] = dt0; dt[1] = dt1;
    for (int p = 0; p < 2; p++) begin
      hold[p]  = (op[p] == OP_HOLD);
      sel_n[p] = (op[p] == OP_IDLE);
      rd_wr[p] = (op[p] == OP_RD);
      addr[p]  = AW'(ad[p]);
      wdata[p] = DW'(dt[p]);
      if (op[p] == OP_RD) begin
        exp_valid[p] = 1'b1;
        exp_word[p]  = ref_mem[ad[p]];
      end else if (op[p] != OP_HOLD) begin
        exp_valid[p] = 1'b0;
      end
    end
    if (op[0] == OP_WR) ref_mem[ad[0]] = DW'(dt[0]);
    if (op[1] == OP_WR && !(op[0] == OP_WR && ad[0] == ad[1])) ref_mem[ad[1]] = DW'(dt[1]);
    @(posedge clk);
    @(negedge clk);
    check_ports(tag);
  endtask

  task automatic oe_probe();
    oe_n = 2'b11;
    #1;
    for (int p = 0; p < 2; p++) begin
      check("R6", p, "drive_oe_off", 32'(drive[p]), 32'd0);
      check("R6", p, "rdata_oe_off", 32'(rdata[p]), 32'd0);
    end
    oe_n = 2'b00;
    #1;
    for (int p = 0; p < 2; p++)
      check("R6", p, "drive_oe_on", 32'(drive[p]), 32'(exp_valid[p]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    for (int p = 0; p < 2; p++) begin
      exp_valid[p] = 1'b0;
      check("R9", p, "rvalid_rst", 32'(rvalid[p]), 32'd0);
      check("R9", p, "drive_rst",  32'(drive[p]),  32'd0);
      check("R9", p, "rdata_rst",  32'(rdata[p]),  32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int pool_addr(int idx);
    return (idx < 32) ? idx : (DEPTH - 64 + idx);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    hold = 2'b00; sel_n = 2'b11; rd_wr = 2'b11; oe_n = 2'b00;
    for (int p = 0; p < 2; p++) begin
      addr[p] = '0; wdata[p] = '0; exp_valid[p] = 1'b0; exp_word[p] = '0;
    end
    repeat (2) @(negedge clk);
    // R9: state while held in reset from time zero
    for (int p = 0; p < 2; p++) begin
      check("R9", p, "rvalid_init", 32'(rvalid[p]), 32'd0);
      check("R9", p, "drive_init",  32'(drive[p]),  32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fill the low and high ends of the array from both sides, read back crosswise
    for (int i = 0; i < 32; i++)
      step(OP_WR, i, int'($urandom % 512), OP_WR, DEPTH - 32 + i, int'($urandom % 512), "R4");
    for (int i = 0; i < 32; i++)
      step(OP_RD, DEPTH - 32 + i, 0, OP_RD, i, 0, "R1");

    // R1: top data bit is ordinary storage
    step(OP_WR, 5, 9'h100, OP_IDLE, 0, 0, "R4");
    step(OP_IDLE, 0, 0, OP_RD, 5, 0, "R1");
    step(OP_IDLE, 0, 0, OP_WR, 6, 9'h1FF, "R4");
    step(OP_RD, 6, 0, OP_IDLE, 0, 0, "R1");
    oe_probe();

    // R7: write on one side, read of the same word on the other side in the same edge
    step(OP_WR, 7, 9'h0AA, OP_RD, 7, 0, "R7");
    step(OP_IDLE, 0, 0, OP_RD, 7, 0, "R7");
    step(OP_RD, 8, 0, OP_WR, 8, 9'h155, "R7");
    step(OP_RD, 8, 0, OP_IDLE, 0, 0, "R7");

    // R8: both sides write one word in one edge, left data must stay
    for (int k = 0; k < 4; k++) begin
      step(OP_WR, 9 + k, 9'h111 + k, OP_WR, 9 + k, 9'h0EE - k, "R8");
      step(OP_RD, 9 + k, 0, OP_RD, 9 + k, 0, "R8");
    end

    // R3: held port keeps its read and drops a presented write
    step(OP_RD, 3, 0, OP_RD, 4, 0, "R2");
    step(OP_HOLD, 3, 9'h0F0, OP_HOLD, 4, 9'h00F, "R3");
    oe_probe();
    step(OP_RD, 3, 0, OP_RD, 4, 0, "R3");

    // R5: deselect with output enable asserted
    step(OP_IDLE, 3, 0, OP_IDLE, 4, 0, "R5");
    step(OP_RD, 2, 0, OP_IDLE, 0, 0, "R2");
    step(OP_IDLE, 0, 0, OP_HOLD, 2, 9'h033, "R5");

    // R9: reset in mid-run keeps the array
    step(OP_RD, 1, 0, OP_RD, 2, 0, "R2");
    do_reset();
    step(OP_RD, 5, 0, OP_RD, 6, 0, "R9");

    // Random mix with forced address overlap
    for (int it = 0; it < 2500; it++) begin
      int o0, o1, a0, a1;
      o0 = int'($urandom % 4);
      o1 = int'($urandom % 4);
      a0 = pool_addr(int'($urandom % 64));
      a1 = (($urandom % 4) == 0) ? a0 : pool_addr(int'($urandom % 64));
      step(o0, a0, int'($urandom % 512), o1, a1, int'($urandom % 512), "R2");
      if ((it % 16) == 0) oe_probe();
    end

    report();
    $finish;
  end
endmodule